// File: doc/BRIEF.md
# Staged-Write Byte-Lane Register Target

This block is the responding end of a narrow register-access link. The link carries one byte per clock in each direction. A requester sends commands, 12-bit addresses and write data over the inbound byte lane, a few bytes per transaction. The block decodes these bytes and holds a small bank of 8-bit registers. The register contents drive local logic directly through a flat output vector.

Writes happen in two phases. Staging writes are held in a small buffer and do not change the registers. A committing write then makes every staged write, plus its own data, land in the registers in a single clock cycle. The block acknowledges that update on the outbound lane. A read returns a two-byte completion on the outbound lane after a fixed delay.

Each register has level bits, which hold their value, and self-clearing bits, which stay high for one cycle only.

Top module: `mbus_reg_target`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, and in the cycle after it is released, every register reads 0x00, `tx_byte` is 0x00 and `wbuf_ovf` is 0.
- R2: A transaction is framed across consecutive inbound bytes:
  - First byte: command in bits [7:4] and address bits [11:8] in bits [3:0].
  - Second byte: address bits [7:0].
  - Third byte (writes only): the data.
  - Command codes: NOP 0x0, staging write 0x1, committing write 0x2, read 0x3, read completion 0x4, write acknowledge 0x5.
  - A first byte carrying any code other than 0x1, 0x2 or 0x3 is ignored.
- R3: A read is answered on `tx_byte` in two steps. Call the cycle whose inbound byte holds the low address byte cycle N. The byte 0x40 appears in cycle N+2 and the register value in cycle N+3.
- R4: A staging write leaves every register unchanged.
- R5: A committing write applies all staged writes, in arrival order, and then its own write. All of these land in the register outputs in the same cycle. A later write to the same address wins. The stage is then empty.
- R6: Call the cycle whose inbound byte holds the committing write's data cycle N. `tx_byte` is 0x50 in cycle N+2, the same cycle in which the updated registers first appear. `tx_byte` is 0x00 in every cycle that carries no response byte.
- R7: NOP bytes between staging writes and the committing write do not alter the staged contents.
- R8: Level bits keep their value until the next committed write to that register. Level bits are the bits not set in `PULSE_MASK`; the default mask is 0x80, so the level bits are [6:0].
- R9: A self-clearing bit (bit 7 by default) written to 1 reads 1 for exactly the first cycle of the update and 0 after that. A read completion therefore never shows it set.
- R10: The stage holds `WBUF_DEPTH` entries (default 8). A staging write that arrives when the stage is full is dropped, and `wbuf_ovf` pulses high for one cycle. Call the cycle of that write's data byte cycle N; the pulse appears in cycle N+2.
- R11: An address outside the mapped registers reads back 0x00, and writes to it change no register.
- R12: Address bits [11:10] select one of four regions: 0 receiver, 1 transmitter, 2 common, 3 vendor. Bits [9:0] are the offset, and only offsets below `REGS_PER_REGION` (default 4) are mapped. The register index is region*`REGS_PER_REGION`+offset, and it appears at `reg_q[index*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Inbound command/address/data lane |
| tx_byte | output | 8 | Outbound completion/acknowledge lane, registered |
| reg_q | output | 4*REGS_PER_REGION*8 | Flattened register contents |
| wbuf_ovf | output | 1 | One-cycle pulse when a staging write is dropped |

## Verification
The assertions rely on the requester keeping to the link rules:
- Transactions never overlap.
- After a committing write, no new command starts until the acknowledge has been seen.
- Under these rules a read completion and an acknowledge never compete for the outbound lane.

The stimulus keeps to these rules in three ways:
- It sends every transaction as a complete byte run.
- After each write it returns the lane to NOP.
- It waits out each completion or acknowledge before issuing the next transaction.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam logic [3:0] CMD_NOP       = 4'h0;
  localparam logic [3:0] CMD_WR_STAGE  = 4'h1;
  localparam logic [3:0] CMD_WR_COMMIT = 4'h2;
  localparam logic [3:0] CMD_RD        = 4'h3;
  localparam logic [3:0] CMD_RD_CPL    = 4'h4;
  localparam logic [3:0] CMD_WR_ACK    = 4'h5;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ALO  = 2'd1,
    PH_DATA = 2'd2
  } mbus_phase_e;
endpackage

// File: rtl/mbus_rx_decoder.sv
module mbus_rx_decoder
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_byte,
  output logic              rd_vld,
  output logic              wr_vld,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  mbus_phase_e phase_q;
  logic [3:0]  cmd_q;
  logic [3:0]  ahi_q;
  logic [7:0]  alo_q;
  logic        opens;

  assign opens = (rx_byte[7:4] == CMD_WR_STAGE) ||
                 (rx_byte[7:4] == CMD_WR_COMMIT) ||
                 (rx_byte[7:4] == CMD_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_CMD;
      cmd_q     <= CMD_NOP;
      ahi_q     <= '0;
      alo_q     <= '0;
      rd_vld    <= 1'b0;
      wr_vld    <= 1'b0;
      wr_commit <= 1'b0;
      addr      <= '0;
      data      <= '0;
    end else begin
      rd_vld    <= 1'b0;
      wr_vld    <= 1'b0;
      wr_commit <= 1'b0;
      case (phase_q)
        PH_CMD: begin
          if (opens) begin
            cmd_q   <= rx_byte[7:4];
            ahi_q   <= rx_byte[3:0];
            phase_q <= PH_ALO;
          end
        end
        PH_ALO: begin
          alo_q <= rx_byte;
          if (cmd_q == CMD_RD) begin
            rd_vld  <= 1'b1;
            addr    <= {ahi_q, rx_byte};
            phase_q <= PH_CMD;
          end else begin
            phase_q <= PH_DATA;
          end
        end
        default: begin
          wr_vld    <= 1'b1;
          wr_commit <= (cmd_q == CMD_WR_COMMIT);
          addr      <= {ahi_q, alo_q};
          data      <= rx_byte;
          phase_q   <= PH_CMD;
        end
      endcase
    end
  end

  // A read request and a write request are never issued in the same cycle
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(rd_vld && wr_vld)); // R2
endmodule

// File: rtl/mbus_wbuf.sv
module mbus_wbuf
  import mbus_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         stage,
  input  logic                         commit,
  input  logic [ADDR_W-1:0]            in_addr,
  input  logic [DATA_W-1:0]            in_data,
  output logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  output logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  output logic [CW-1:0]                cnt,
  output logic                         ovf
);
  logic full;
  assign full = (cnt == CW'(DEPTH));

  // Entry storage carries no reset; only the count qualifies it
  always_ff @(posedge clk) begin
    if (stage && !commit && !full) begin
      ent_addr[cnt[IW-1:0]] <= in_addr;
      ent_data[cnt[IW-1:0]] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (commit) begin
        cnt <= '0;
      end else if (stage) begin
        if (full) ovf <= 1'b1;
        else      cnt <= cnt + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R10
  AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    commit |=> (cnt == '0)); // R5
  AST_STAGE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!stage && !commit) |=> $stable(cnt)); // R7
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
  import mbus_pkg::*;
#(
  parameter int          REGS_PER_REGION = 4,
  parameter int          DEPTH           = 8,
  parameter logic [7:0]  PULSE_MASK      = 8'h80,
  localparam int         NUM_REGS        = 4 * REGS_PER_REGION,
  localparam int         CW              = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         apply,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [CW-1:0]                ent_cnt,
  input  logic [ADDR_W-1:0]            c_addr,
  input  logic [DATA_W-1:0]            c_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_REGS*8-1:0]        reg_q
);
  localparam logic [NUM_REGS*8-1:0] PM_ALL = {NUM_REGS{PULSE_MASK}};

  logic [7:0] regs [NUM_REGS];
  logic [7:0] nxt  [NUM_REGS];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return (a[11:10] == 2'(idx / REGS_PER_REGION)) &&
           (a[9:0] == 10'(idx % REGS_PER_REGION));
  endfunction

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      nxt[r] = regs[r] & ~PULSE_MASK;
      if (apply) begin
        for (int i = 0; i < DEPTH; i++) begin
          if ((CW'(i) < ent_cnt) && hit(ent_addr[i], r)) nxt[r] = ent_data[i];
        end
        if (hit(c_addr, r)) nxt[r] = c_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rst) regs[r] <= '0;
      else     regs[r] <= nxt[r];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (hit(rd_addr, r)) rd_data = regs[r];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign reg_q[g*8 +: 8] = regs[g];
  end

  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !apply |=> ((reg_q & PM_ALL) == '0)); // R9
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !apply |=> ((reg_q & ~PM_ALL) == $past(reg_q & ~PM_ALL))); // R8
endmodule

// File: rtl/mbus_reg_target.sv
module mbus_reg_target
  import mbus_pkg::*;
#(
  parameter int         REGS_PER_REGION = 4,
  parameter int         WBUF_DEPTH      = 8,
  parameter logic [7:0] PULSE_MASK      = 8'h80
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [7:0]                     rx_byte,
  output logic [7:0]                     tx_byte,
  output logic [4*REGS_PER_REGION*8-1:0] reg_q,
  output logic                           wbuf_ovf
);
  localparam int CW = $clog2(WBUF_DEPTH + 1);

  logic              rd_vld, wr_vld, wr_commit;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic [WBUF_DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [WBUF_DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [CW-1:0]     ent_cnt;
  logic [DATA_W-1:0] rd_data;
  logic              commit_go;
  logic              pend_vld;
  logic [7:0]        pend_data;

  assign commit_go = wr_vld && wr_commit;

  mbus_rx_decoder u_dec (
    .clk(clk), .rst(rst), .rx_byte(rx_byte),
    .rd_vld(rd_vld), .wr_vld(wr_vld), .wr_commit(wr_commit),
    .addr(req_addr), .data(req_data)
  );

  mbus_wbuf #(.DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk(clk), .rst(rst),
    .stage(wr_vld && !wr_commit), .commit(commit_go),
    .in_addr(req_addr), .in_data(req_data),
    .ent_addr(ent_addr), .ent_data(ent_data), .cnt(ent_cnt), .ovf(wbuf_ovf)
  );

  mbus_regfile #(
    .REGS_PER_REGION(REGS_PER_REGION), .DEPTH(WBUF_DEPTH), .PULSE_MASK(PULSE_MASK)
  ) u_rf (
    .clk(clk), .rst(rst), .apply(commit_go),
    .ent_addr(ent_addr), .ent_data(ent_data), .ent_cnt(ent_cnt),
    .c_addr(req_addr), .c_data(req_data),
    .rd_addr(req_addr), .rd_data(rd_data), .reg_q(reg_q)
  );

  // Outbound lane: completion header, then its data byte; acknowledge single byte
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte   <= '0;
      pend_vld  <= 1'b0;
      pend_data <= '0;
    end else begin
      pend_vld <= 1'b0;
      if (pend_vld) begin
        tx_byte <= pend_data;
      end else if (rd_vld) begin
        tx_byte   <= {CMD_RD_CPL, 4'h0};
        pend_data <= rd_data & ~PULSE_MASK;
        pend_vld  <= 1'b1;
      end else if (commit_go) begin
        tx_byte <= {CMD_WR_ACK, 4'h0};
      end else begin
        tx_byte <= '0;
      end
    end
  end

  AST_CPL_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !pend_vld) |=> (tx_byte == {CMD_RD_CPL, 4'h0})); // R3
  AST_ACK_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (commit_go && !pend_vld && !rd_vld) |=> (tx_byte == {CMD_WR_ACK, 4'h0})); // R6
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rd_vld && !commit_go && !pend_vld) |=> (tx_byte == 8'h00)); // R6
endmodule

// File: tb/mbus_reg_target_tb_top.sv
module mbus_reg_target_tb_top;
  localparam int RPR = 4;
  localparam int DEPTH = 8;
  localparam int NREG = 4 * RPR;
  localparam logic [7:0] PM = 8'h80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rx = 8'h00;
  logic [7:0] tx;
  logic [NREG*8-1:0] regs;
  logic ovf;

  always #10 clk = ~clk;

  mbus_reg_target #(.REGS_PER_REGION(RPR), .WBUF_DEPTH(DEPTH), .PULSE_MASK(PM)) dut_i (
    .clk(clk), .rst(rst), .rx_byte(rx), .tx_byte(tx), .reg_q(regs), .wbuf_ovf(ovf)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {int cyc; int kind; logic [7:0] val; string tag;} exp_t;
  exp_t expq[$];
  typedef struct {logic [11:0] a; logic [7:0] d;} wr_t;
  wr_t stq[$];
  logic [7:0] model [NREG];
  bit wrote [NREG];
  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int idx_of(logic [11:0] a);
    if (a[9:0] < RPR) return int'(a[11:10]) * RPR + int'(a[9:0]);
    return -1;
  endfunction

  // Monitor: pops scoreboard items due this cycle and compares the output lanes
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        logic [7:0] etx;
        logic eovf;
        string ttx;
        string tovf;
        etx = 8'h00; eovf = 1'b0; ttx = "R6 idle"; tovf = "R10 idle";
        for (int i = expq.size() - 1; i >= 0; i--) begin
          if (expq[i].cyc == cyc) begin
            if (expq[i].kind == 0) begin etx = expq[i].val; ttx = expq[i].tag; end
            else begin eovf = expq[i].val[0]; tovf = expq[i].tag; end
            expq.delete(i);
          end
        end
        chk(ttx, tx, etx);
        chk(tovf, ovf, eovf);
      end
    end
  end

  task automatic put(logic [7:0] b);
    @(negedge clk);
    rx = b;
  endtask

  task automatic check_all(string tag, bit show_pulse);
    for (int r = 0; r < NREG; r++) begin
      logic [7:0] e;
      e = (show_pulse && wrote[r]) ? model[r] : (model[r] & ~PM);
      chk(tag, regs[r*8 +: 8], e);
    end
  endtask

  task automatic do_read(logic [11:0] a, string tag);
    int n, k;
    logic [7:0] e;
    put({4'h3, a[11:8]});
    put(a[7:0]);
    n = cyc;
    k = idx_of(a);
    e = (k >= 0) ? (model[k] & ~PM) : 8'h00;
    expq.push_back('{n + 2, 0, 8'h40, tag});
    expq.push_back('{n + 3, 0, e, tag});
    repeat (3) put(8'h00);
  endtask

  task automatic do_wu(logic [11:0] a, logic [7:0] d);
    int n;
    put({4'h1, a[11:8]});
    put(a[7:0]);
    put(d);
    n = cyc;
    if (stq.size() < DEPTH) stq.push_back('{a, d});
    else expq.push_back('{n + 2, 1, 8'h01, "R10 overflow"});
    put(8'h00);
  endtask

  task automatic do_wc(logic [11:0] a, logic [7:0] d);
    int n, k;
    put({4'h2, a[11:8]});
    put(a[7:0]);
    put(d);
    n = cyc;
    for (int r = 0; r < NREG; r++) wrote[r] = 1'b0;
    foreach (stq[i]) begin
      k = idx_of(stq[i].a);
      if (k >= 0) begin model[k] = stq[i].d; wrote[k] = 1'b1; end
    end
    k = idx_of(a);
    if (k >= 0) begin model[k] = d; wrote[k] = 1'b1; end
    stq.delete();
    expq.push_back('{n + 2, 0, 8'h50, "R6 ack"});
    put(8'h00);
    put(8'h00);
    check_all("R5 commit update", 1'b1);
    put(8'h00);
    check_all("R9 pulse cleared", 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) begin model[r] = 8'h00; wrote[r] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1 reset tx", tx, 8'h00);
    chk("R1 reset ovf", ovf, 1'b0);
    check_all("R1 reset regs", 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 after release", 1'b0);

    // R2: stray codes in the command position are ignored
    put(8'h45); put(8'h5F); put(8'h00); put(8'h7A); put(8'hF3); put(8'h00); put(8'h00);
    check_all("R2 ignored codes", 1'b0);
    do_read(12'h801, "R2 read zero");

    // single committing write, R3 readback
    do_wc(12'h800, 8'h5A);
    do_read(12'h800, "R3 readback");

    // R4/R5/R7: staging with NOPs, same address twice
    do_wu(12'h001, 8'h11);
    repeat (3) put(8'h00);  // R7 NOPs inside the stage
    do_wu(12'h402, 8'h22);
    do_wu(12'hC03, 8'h33);
    do_wu(12'h001, 8'h44);
    check_all("R4 staged not applied", 1'b0);
    do_read(12'h001, "R4 read during stage");
    do_wc(12'h803, 8'h66);
    do_read(12'h001, "R5 later write wins");
    do_read(12'hC03, "R12 vendor region");
    do_read(12'h402, "R7 survives NOPs");

    // R8/R9: self-clearing top bit, level bits hold
    do_wc(12'h400, 8'hFF);
    do_read(12'h400, "R9 pulse hidden on read");
    repeat (5) put(8'h00);
    check_all("R8 level hold", 1'b0);

    // R11: unmapped addresses
    do_wu(12'h004, 8'h99);
    do_wc(12'h3FF, 8'hAB);
    check_all("R11 unmapped write", 1'b0);
    do_read(12'h004, "R11 unmapped read");
    do_read(12'h7FF, "R11 unmapped read hi");

    // R10: ninth staging write dropped
    for (int i = 0; i < DEPTH + 1; i++) do_wu(12'h401, (i == DEPTH) ? 8'hEE : 8'(i + 1));
    do_wc(12'h402, 8'h12);
    do_read(12'h401, "R10 dropped entry");

    repeat (6) put(8'h00);
    if (expq.size() != 0) chk("R3 pending items", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule